// File: doc/BRIEF.md
# Reserving Set-Associative Tag Store

This block is the tag and line-state store of a non-blocking cache. It keeps no data. For every line it holds a tag, a two-bit state and two age stamps. A request on the lookup port is resolved combinationally in the cycle it is presented. The response gives a four-way result code and the line that was matched or chosen. When the chosen victim holds dirty data, the response also gives a write-back flag and the victim's block address. The line state is updated at the next clock edge.

A line allocated on a miss is marked reserved until the fill port reports that its data has arrived. A lookup that matches a reserved line reports a pending hit. Reserved lines are never evicted, so a set whose ways are all reserved refuses the miss and changes nothing. The fill port names its target either by address or directly by line number. A flush input empties the whole store in one cycle. A parameter picks the victim rule: least recently used or first in, first out. Three counters record accesses, misses and pending hits.

Top module: `tag_reserve_array`

## Requirements
- R1: After reset every line is invalid and all three counters are zero. A lookup then reports MISS, selects way 0 of its set and drives the write-back flag low.
- R2: The byte-offset width is log2(LINE_BYTES). The set is the next log2(SETS) address bits above the offset, and the tag is every bit above those. The reported line number is set*WAYS + way. A block address is the address with the offset bits cleared, so offset bits never affect the result.
- R3: The result code is 0 (HIT) when the tag matches a valid or modified line, 1 (HIT_RESERVED) when it matches a reserved line, 2 (MISS) when a victim can be allocated, and 3 (RESERVATION_FAIL) otherwise.
- R4: On a MISS the victim is the lowest-numbered invalid way, if there is one. The victim takes the new tag and becomes reserved, so the next lookup of the same block reports HIT_RESERVED on that line.
- R5: A reserved line is never chosen as a victim. When every way of the set is reserved, the result is RESERVATION_FAIL and no line changes.
- R6: A fill, given either by address or by line number, moves a reserved line to valid. A fill that names a line in any other state has no effect, and a modified line that receives one stays dirty.
- R7: With the least-recently-used rule, when no way is invalid the victim is the valid or modified way whose last hit or allocation is oldest. Ties go to the lowest way.
- R8: With the first-in rule, when no way is invalid the victim is the valid or modified way allocated earliest. Ties go to the lowest way.
- R9: A write lookup that hits a valid or modified line marks it modified. A MISS whose victim is modified raises the write-back flag and drives the victim's block address; every other result keeps the flag low.
- R10: A probe lookup reports the same result and line as a normal lookup, but it changes no line state, age stamp or counter.
- R11: A flush makes every line invalid at the next edge and leaves the counters unchanged. A lookup or fill presented in the same cycle as a flush is ignored.
- R12: Every non-probe lookup increments the access counter. MISS and RESERVATION_FAIL each increment the miss counter, and HIT_RESERVED increments the pending counter.
- R13: The result, line, flag and address are valid in the same cycle as the request. The line state they cause is visible to a lookup in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_probe | input | 1 | Lookup is a probe and updates nothing |
| lk_write | input | 1 | Lookup is a write; a hit marks the line modified |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_status | output | 2 | Result code (0 hit, 1 pending hit, 2 miss, 3 refused) |
| lk_line | output | log2(SETS*WAYS) | Matched or chosen line number |
| lk_wb | output | 1 | Victim is modified and must be written back |
| lk_wb_addr | output | ADDR_W | Block address of the victim |
| fl_valid | input | 1 | Fill request present |
| fl_by_line | input | 1 | Fill names a line number rather than an address |
| fl_addr | input | ADDR_W | Fill byte address |
| fl_line | input | log2(SETS*WAYS) | Fill line number |
| flush | input | 1 | Invalidate every line |
| cnt_access | output | CNT_W | Non-probe lookups since reset |
| cnt_miss | output | CNT_W | Misses and refusals since reset |
| cnt_pend | output | CNT_W | Pending hits since reset |

## Verification
On every cycle the embedded properties check several invariants. At most one way of a set matches a tag, and no victim is ever a reserved line. A miss leaves its line reserved and a legal fill leaves its line valid. A refusal, a probe or a flush leaves the state exactly as its requirement says. The write-back flag appears only with a miss, and each counter steps by one per event. Only the bench's scenarios can show which way the two replacement rules pick, how ignored fills keep dirty data, and how offsets and sets map to line numbers. They do this by comparing both policy instances with an arithmetic reference model across a long pseudo-random sweep.

// File: rtl/tagr_pkg.sv
// Shared encodings for the reserving tag store.
// Assumes: both encodings are two bits wide and visible at the ports as plain vectors.
package tagr_pkg;

    typedef enum logic [1:0] {
        LS_INVALID  = 2'd0,
        LS_RESERVED = 2'd1,
        LS_VALID    = 2'd2,
        LS_MODIFIED = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        RS_HIT      = 2'd0,
        RS_HIT_RSV  = 2'd1,
        RS_MISS     = 2'd2,
        RS_FAIL     = 2'd3
    } look_result_e;

endpackage

// File: rtl/tagr_addr_split.sv
// Splits a byte address into set number and tag.
// Assumes: line size and set count are powers of two, so fields are plain bit slices.
module tagr_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    // Field extraction: set above the offset, tag above the set.
    assign set_idx = addr[OFF_W +: IDX_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/tagr_victim.sv
// Picks the way to replace within one set.
// Prefers the lowest invalid way; otherwise the oldest valid or modified way
// by the supplied age. Reserved ways are never candidates.
// Assumes: ages are precomputed as (now - stamp) modulo 2**STAMP_W.
module tagr_victim
    import tagr_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int WAY_W   = 2,
    parameter int STAMP_W = 16
) (
    input  logic [WAYS-1:0][1:0]         way_st,
    input  logic [WAYS-1:0][STAMP_W-1:0] way_age,
    output logic                         found,
    output logic [WAY_W-1:0]             way
);
    logic               have_inv;
    logic [STAMP_W-1:0] best;

    // Victim scan: invalid first, else maximum age with lowest-way tie break.
    always_comb begin
        found    = 1'b0;
        way      = '0;
        have_inv = 1'b0;
        best     = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_st[w] == LS_INVALID && !have_inv) begin
                have_inv = 1'b1;
                found    = 1'b1;
                way      = WAY_W'(w);
            end
        end
        if (!have_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if ((way_st[w] == LS_VALID || way_st[w] == LS_MODIFIED) &&
                    (!found || way_age[w] > best)) begin
                    found = 1'b1;
                    way   = WAY_W'(w);
                    best  = way_age[w];
                end
            end
        end
    end
endmodule

// File: rtl/tagr_counters.sv
// Event counters for accesses, misses and pending hits.
// Assumes: event strobes are already gated by probe and flush in the parent.
module tagr_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_access,
    input  logic             ev_miss,
    input  logic             ev_pend,
    output logic [CNT_W-1:0] cnt_access,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_pend
);
    // Count each strobe; synchronous clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_access <= '0;
            cnt_miss   <= '0;
            cnt_pend   <= '0;
        end else begin
            if (ev_access) cnt_access <= cnt_access + 1'b1;
            if (ev_miss)   cnt_miss   <= cnt_miss + 1'b1;
            if (ev_pend)   cnt_pend   <= cnt_pend + 1'b1;
        end
    end

    p_miss_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_miss |=> cnt_miss == $past(cnt_miss) + 1'b1);
    p_access_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_access |=> cnt_access == $past(cnt_access) + 1'b1);
    p_pend_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pend |=> $stable(cnt_pend));
endmodule

// File: rtl/tag_reserve_array.sv
// Set-associative tag and state store with reserved (in-flight) lines.
// Lookup resolves combinationally; state, stamps and counters update on the
// next edge. Fill moves a reserved line to valid. Flush clears every line.
// Assumes: LINE_BYTES, SETS and WAYS are powers of two, with SETS and WAYS at least 2.
module tag_reserve_array
    import tagr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int USE_LRU    = 1,
    parameter int STAMP_W    = 16,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int LINES     = SETS * WAYS,
    localparam int LINE_W    = IDX_W + WAY_W,
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_probe,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [1:0]        lk_status,
    output logic [LINE_W-1:0] lk_line,
    output logic              lk_wb,
    output logic [ADDR_W-1:0] lk_wb_addr,
    input  logic              fl_valid,
    input  logic              fl_by_line,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [LINE_W-1:0] fl_line,
    input  logic              flush,
    output logic [CNT_W-1:0]  cnt_access,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_pend
);
    // Line storage.
    logic [LINES-1:0][1:0]         line_st;
    logic [LINES-1:0][TAG_W-1:0]   line_tag;
    logic [LINES-1:0][STAMP_W-1:0] line_alloc;
    logic [LINES-1:0][STAMP_W-1:0] line_used;
    logic [LINES-1:0][STAMP_W-1:0] pol_stamp;
    logic [STAMP_W-1:0]            tick;

    // Lookup path.
    logic [IDX_W-1:0]              lk_set;
    logic [TAG_W-1:0]              lk_tag;
    logic [WAYS-1:0][1:0]          set_st;
    logic [WAYS-1:0][TAG_W-1:0]    set_tag;
    logic [WAYS-1:0][STAMP_W-1:0]  set_age;
    logic [WAYS-1:0]               hit_vec;
    logic                          hit_any;
    logic [WAY_W-1:0]              hit_way;
    logic                          vic_found;
    logic [WAY_W-1:0]              vic_way;
    look_result_e                  res;
    logic                          lk_do;

    // Fill path.
    logic [IDX_W-1:0]              fl_set;
    logic [TAG_W-1:0]              fl_tag;
    logic                          fl_match;
    logic [WAY_W-1:0]              fl_way;
    logic [LINE_W-1:0]             fill_line;
    logic                          fill_ok;

    tagr_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_lk_split (.addr(lk_addr), .set_idx(lk_set), .tag(lk_tag));

    tagr_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_fl_split (.addr(fl_addr), .set_idx(fl_set), .tag(fl_tag));

    // Replacement rule picks which stamp counts as age.
    generate
        if (USE_LRU != 0) begin : g_lru
            assign pol_stamp = line_used;
        end else begin : g_fifo
            assign pol_stamp = line_alloc;
        end
    endgenerate

    // Gather the addressed set and compare tags.
    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            set_st[w]  = line_st[{lk_set, WAY_W'(w)}];
            set_tag[w] = line_tag[{lk_set, WAY_W'(w)}];
            set_age[w] = tick - pol_stamp[{lk_set, WAY_W'(w)}];
            hit_vec[w] = (set_st[w] != LS_INVALID) && (set_tag[w] == lk_tag);
            if (hit_vec[w] && !hit_any) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    tagr_victim #(.WAYS(WAYS), .WAY_W(WAY_W), .STAMP_W(STAMP_W)) u_victim (
        .way_st  (set_st),
        .way_age (set_age),
        .found   (vic_found),
        .way     (vic_way)
    );

    // Result code, line number and write-back outputs.
    always_comb begin
        if (hit_any)
            res = (set_st[hit_way] == LS_RESERVED) ? RS_HIT_RSV : RS_HIT;
        else if (vic_found)
            res = RS_MISS;
        else
            res = RS_FAIL;
        lk_status  = res;
        lk_line    = hit_any ? {lk_set, hit_way} : {lk_set, vic_way};
        lk_wb      = lk_valid && (res == RS_MISS) && (set_st[vic_way] == LS_MODIFIED);
        lk_wb_addr = {set_tag[vic_way], lk_set, OFF_W'(0)};
    end

    // Locate the fill target and check that it is reserved.
    always_comb begin
        fl_match = 1'b0;
        fl_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!fl_match && line_st[{fl_set, WAY_W'(w)}] == LS_RESERVED &&
                line_tag[{fl_set, WAY_W'(w)}] == fl_tag) begin
                fl_match = 1'b1;
                fl_way   = WAY_W'(w);
            end
        end
        fill_line = fl_by_line ? fl_line : {fl_set, fl_way};
        fill_ok   = fl_valid && (fl_by_line ? (line_st[fl_line] == LS_RESERVED) : fl_match);
    end

    assign lk_do = lk_valid && !lk_probe && !flush;

    // Line state and stamp update: flush, then fill and lookup on disjoint lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_st    <= '0;
            line_tag   <= '0;
            line_alloc <= '0;
            line_used  <= '0;
            tick       <= '0;
        end else if (flush) begin
            line_st <= '0;
        end else begin
            if (fill_ok)
                line_st[fill_line] <= LS_VALID;
            if (lk_do) begin
                tick <= tick + 1'b1;
                if (res == RS_HIT) begin
                    line_used[lk_line] <= tick;
                    if (lk_write)
                        line_st[lk_line] <= LS_MODIFIED;
                end else if (res == RS_MISS) begin
                    line_st[lk_line]    <= LS_RESERVED;
                    line_tag[lk_line]   <= lk_tag;
                    line_alloc[lk_line] <= tick;
                    line_used[lk_line]  <= tick;
                end
            end
        end
    end

    tagr_counters #(.CNT_W(CNT_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_access  (lk_do),
        .ev_miss    (lk_do && (res == RS_MISS || res == RS_FAIL)),
        .ev_pend    (lk_do && (res == RS_HIT_RSV)),
        .cnt_access (cnt_access),
        .cnt_miss   (cnt_miss),
        .cnt_pend   (cnt_pend)
    );

    // Guards next to the logic above.
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(hit_vec));
    p_victim_not_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_status == 2'd2) |-> set_st[vic_way] != LS_RESERVED);
    p_miss_reserves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_do && lk_status == 2'd2) |=> line_st[$past(lk_line)] == LS_RESERVED);
    p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ok && !flush) |=> line_st[$past(fill_line)] == LS_VALID);
    p_fail_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_do && lk_status == 2'd3 && !fl_valid) |=> $stable(line_st) && $stable(line_tag));
    p_probe_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_probe && !fl_valid && !flush) |=>
            $stable(line_st) && $stable(line_used) && $stable(tick));
    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> line_st == '0);
    p_wb_on_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_wb |-> lk_status == 2'd2);
endmodule

// File: tb/sim_tag_reserve_array.sv
// Bench: two instances (least-recently-used and first-in) on shared inputs,
// directed corner cases followed by a pseudo-random sweep against a bench model.
module sim_tag_reserve_array;
    localparam int AW = 12;
    localparam int LW = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 0, lk_probe = 0, lk_write = 0;
    logic [AW-1:0] lk_addr = '0;
    logic          fl_valid = 0, fl_by_line = 0;
    logic [AW-1:0] fl_addr = '0;
    logic [LW-1:0] fl_line = '0;
    logic          flush = 0;
    logic [1:0]    st0, st1;
    logic [LW-1:0] ln0, ln1;
    logic          wb0, wb1;
    logic [AW-1:0] wa0, wa1;
    logic [CW-1:0] ca0, cm0, cp0, ca1, cm1, cp1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model, index 0 = LRU instance, 1 = FIFO instance.
    int mst [2][8];
    int mtg [2][8];
    int mal [2][8];
    int mla [2][8];
    int mtick [2];
    int mac [2];
    int mms [2];
    int mpd [2];
    // Last sampled outputs per instance.
    int s_o [2];
    int l_o [2];
    int w_o [2];
    int a_o [2];

    always #10 clk = ~clk;

    tag_reserve_array #(.ADDR_W(AW), .LINE_BYTES(16), .SETS(4), .WAYS(2),
        .USE_LRU(1), .STAMP_W(16), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_probe(lk_probe),
        .lk_write(lk_write), .lk_addr(lk_addr), .lk_status(st0), .lk_line(ln0),
        .lk_wb(wb0), .lk_wb_addr(wa0), .fl_valid(fl_valid), .fl_by_line(fl_by_line),
        .fl_addr(fl_addr), .fl_line(fl_line), .flush(flush),
        .cnt_access(ca0), .cnt_miss(cm0), .cnt_pend(cp0));

    tag_reserve_array #(.ADDR_W(AW), .LINE_BYTES(16), .SETS(4), .WAYS(2),
        .USE_LRU(0), .STAMP_W(16), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_probe(lk_probe),
        .lk_write(lk_write), .lk_addr(lk_addr), .lk_status(st1), .lk_line(ln1),
        .lk_wb(wb1), .lk_wb_addr(wa1), .fl_valid(fl_valid), .fl_by_line(fl_by_line),
        .fl_addr(fl_addr), .fl_line(fl_line), .flush(flush),
        .cnt_access(ca1), .cnt_miss(cm1), .cnt_pend(cp1));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference prediction of one lookup for policy p.
    task automatic mpredict(input int p, input int a, output int rs, output int ln,
                            output int wb, output int wba);
        int s, t, vw, best, age;
        s = (a >> 4) & 3;
        t = (a >> 6) & 63;
        rs = -1; ln = 0; wb = 0; wba = 0;
        for (int w = 0; w < 2; w++)
            if (mst[p][s*2+w] != 0 && mtg[p][s*2+w] == t) begin
                rs = (mst[p][s*2+w] == 1) ? 1 : 0;
                ln = s*2 + w;
            end
        if (rs < 0) begin
            vw = -1;
            for (int w = 0; w < 2; w++)
                if (mst[p][s*2+w] == 0 && vw < 0) vw = w;
            if (vw < 0) begin
                best = -1;
                for (int w = 0; w < 2; w++)
                    if (mst[p][s*2+w] >= 2) begin
                        age = (mtick[p] - ((p == 0) ? mla[p][s*2+w] : mal[p][s*2+w])) & 16'hFFFF;
                        if (age > best) begin best = age; vw = w; end
                    end
            end
            if (vw < 0) rs = 3;
            else begin
                rs  = 2;
                ln  = s*2 + vw;
                wb  = (mst[p][ln] == 3) ? 1 : 0;
                wba = (mtg[p][ln] << 6) | (s << 4);
            end
        end
    endtask

    // One cycle of stimulus: drive at negedge, compare before posedge, update model after.
    task automatic op(input bit lv, input bit pr, input bit wr, input int a,
                      input bit fv, input bit fbl, input int fa, input int fln, input bit fl);
        int rs [2];
        int ln [2];
        int wb [2];
        int wba [2];
        int s, t;
        @(negedge clk);
        lk_valid = lv; lk_probe = pr; lk_write = wr; lk_addr = AW'(a);
        fl_valid = fv; fl_by_line = fbl; fl_addr = AW'(fa); fl_line = LW'(fln);
        flush = fl;
        #5;
        s_o[0] = int'(st0); l_o[0] = int'(ln0); w_o[0] = int'(wb0); a_o[0] = int'(wa0);
        s_o[1] = int'(st1); l_o[1] = int'(ln1); w_o[1] = int'(wb1); a_o[1] = int'(wa1);
        chk("R12 access count u0", int'(ca0), mac[0]);
        chk("R12 miss count u0",   int'(cm0), mms[0]);
        chk("R12 pend count u0",   int'(cp0), mpd[0]);
        chk("R12 access count u1", int'(ca1), mac[1]);
        chk("R12 miss count u1",   int'(cm1), mms[1]);
        chk("R12 pend count u1",   int'(cp1), mpd[1]);
        for (int p = 0; p < 2; p++) begin
            mpredict(p, a, rs[p], ln[p], wb[p], wba[p]);
            if (lv) begin
                chk("R3 result code", s_o[p], rs[p]);
                if (rs[p] != 3) chk("R2 R4 line number", l_o[p], ln[p]);
                chk("R9 write-back flag", w_o[p], wb[p]);
                if (wb[p] != 0) chk("R9 write-back address", a_o[p], wba[p]);
            end
        end
        @(posedge clk);
        #1;
        s = (a >> 4) & 3;
        t = (a >> 6) & 63;
        for (int p = 0; p < 2; p++) begin
            if (fl) begin
                for (int i = 0; i < 8; i++) mst[p][i] = 0;
            end else begin
                if (fv) begin
                    if (fbl) begin
                        if (mst[p][fln] == 1) mst[p][fln] = 2;
                    end else begin
                        for (int w = 0; w < 2; w++)
                            if (mst[p][((fa>>4)&3)*2+w] == 1 &&
                                mtg[p][((fa>>4)&3)*2+w] == ((fa>>6)&63))
                                mst[p][((fa>>4)&3)*2+w] = 2;
                    end
                end
                if (lv && !pr) begin
                    mac[p]++;
                    if (rs[p] >= 2) mms[p]++;
                    if (rs[p] == 1) mpd[p]++;
                    if (rs[p] == 0) begin
                        mla[p][ln[p]] = mtick[p];
                        if (wr) mst[p][ln[p]] = 3;
                    end else if (rs[p] == 2) begin
                        mst[p][ln[p]] = 1;
                        mtg[p][ln[p]] = t;
                        mal[p][ln[p]] = mtick[p];
                        mla[p][ln[p]] = mtick[p];
                    end
                    mtick[p] = (mtick[p] + 1) & 16'hFFFF;
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r;
        for (int p = 0; p < 2; p++) begin
            mtick[p] = 0; mac[p] = 0; mms[p] = 0; mpd[p] = 0;
            for (int i = 0; i < 8; i++) begin
                mst[p][i] = 0; mtg[p][i] = 0; mal[p][i] = 0; mla[p][i] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, probe sees an empty store (R10: probe touches nothing).
        op(1, 1, 0, 'h040, 0, 0, 0, 0, 0);
        chk("R1 reset probe result", s_o[0], 2);
        chk("R1 reset probe line", l_o[0], 0);
        chk("R1 reset wb low", w_o[0], 0);
        // R4, R13: allocate and see the reservation one cycle later.
        op(1, 0, 0, 'h040, 0, 0, 0, 0, 0);
        chk("R4 first miss", s_o[0], 2);
        op(1, 0, 0, 'h040, 0, 0, 0, 0, 0);
        chk("R13 reserved visible next cycle", s_o[0], 1);
        chk("R10 probe left no counter", int'(ca0), 2);
        op(1, 0, 0, 'h080, 0, 0, 0, 0, 0);
        chk("R4 second way", l_o[0], 1);
        // R5: both ways reserved.
        op(1, 0, 0, 'h0C0, 0, 0, 0, 0, 0);
        chk("R5 refused u0", s_o[0], 3);
        chk("R5 refused u1", s_o[1], 3);
        op(1, 1, 0, 'h040, 0, 0, 0, 0, 0);
        chk("R5 state unchanged after refusal", s_o[0], 1);
        // R6: fill by address, then by line number.
        op(0, 0, 0, 0, 1, 0, 'h040, 0, 0);
        op(0, 0, 0, 0, 1, 1, 0, 1, 0);
        op(1, 1, 0, 'h04C, 0, 0, 0, 0, 0);
        chk("R6 fill by address", s_o[0], 0);
        op(1, 1, 0, 'h080, 0, 0, 0, 0, 0);
        chk("R6 fill by line", s_o[1], 0);
        // R9: write hit dirties line 0; R6: later fill on it is ignored.
        op(1, 0, 1, 'h040, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 1, 1, 0, 0, 0);
        // R7 / R8: victims diverge.
        op(1, 0, 0, 'h0C0, 0, 0, 0, 0, 0);
        chk("R7 LRU victim line", l_o[0], 1);
        chk("R7 LRU no write-back", w_o[0], 0);
        chk("R8 FIFO victim line", l_o[1], 0);
        chk("R9 R6 dirty kept, write-back", w_o[1], 1);
        chk("R9 write-back address", a_o[1], 'h040);
        // R11: flush wins over a same-cycle lookup.
        op(1, 0, 0, 'h040, 0, 0, 0, 0, 1);
        op(1, 1, 0, 'h080, 0, 0, 0, 0, 0);
        chk("R11 flushed line misses", s_o[0], 2);
        chk("R11 flush cycle lookup not counted", int'(ca0), 6);
        // R2: offset ignored, set 1 maps to lines 2..3.
        op(1, 0, 0, 'h05F, 0, 0, 0, 0, 0);
        chk("R2 set one line", l_o[0], 2);
        op(1, 0, 0, 'h050, 0, 0, 0, 0, 0);
        chk("R2 offset ignored", s_o[0], 1);

        // Sweep: small tag space for frequent hits, mixed fills, writes, probes, flushes.
        r = 'hACE1;
        for (int i = 0; i < 3000; i++) begin
            int a, fa, k;
            r = ((r << 1) | (((r >> 15) ^ (r >> 13) ^ (r >> 12) ^ (r >> 10)) & 1)) & 'hFFFF;
            a  = r & 'h0FF;
            fa = (r >> 4) & 'h0FF;
            k  = (r >> 8) & 'hF;
            op(k != 0, k == 1, k >= 12, a, k[1] | k[2], k[3], fa, r & 7, (i % 500) == 499);
        end
        op(0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule